// File: doc/BRIEF.md
# Streaming Parallel-Tap Convolution Engine

This block convolves a stream of signed 16-bit samples with a kernel held in on-chip registers. Before a run, software writes each coefficient by index and sets the active kernel length through a small write port. Samples then arrive on a valid/ready stream and enter a shift-register window. The newest sample sits at position 0 and older samples move one position deeper with each new sample. All window positions are multiplied by their coefficients in one cycle. A registered binary adder tree sums the products at full precision. A final stage clamps the sum to the signed 16-bit range and presents it on a valid/ready output stream.

The datapath is fully unrolled: it has one multiplier per tap position, and every tree level is a pipeline register. A shorter kernel uses the same hardware, because coefficients at or beyond the programmed length are forced to zero. A stalled output freezes every stage, including the window shift. No sample is lost and no result is repeated. Each accepted sample yields exactly one result. To flush the trailing part of a convolution, push length-minus-one zero samples after the last real sample.

Top module: `tapconv_top`

## Requirements
- R1: Reset (synchronous, active high) clears these: output valid goes low, input ready goes high, all coefficients become zero, the window holds zeros and the active length becomes TAPS.
- R2: A write with `coef_we` high stores `coef_val` as coefficient k = `coef_idx`. Coefficient k multiplies the sample accepted k samples before the current one.
- R3: The result for the n-th accepted sample is y[n] = sum over k < L of h[k]·x[n-k]. Here L is the active length, and samples before the first accepted one count as zero.
- R4: A write with `len_we` high sets L to `len_val`. Values above TAPS are taken as TAPS, and 0 makes every result zero. Coefficients at index L or above have no effect on the results.
- R5: Results above 32767 are output as 32767, results below -32768 are output as -32768, and values inside the range pass unchanged.
- R6: Products and partial sums keep full precision. Intermediate sums far outside 32 bits that cancel to an in-range total yield the exact total.
- R7: With the output ready held high, the result for a sample accepted at clock edge n becomes valid after edge n + LVL + 2. LVL is ceil(log2(TAPS)), or 0 when TAPS is 1.
- R8: Results leave in the order the samples were accepted, one per sample, with none dropped or repeated. While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold steady.
- R9: `s_ready` is low exactly when `m_valid` is high and `m_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | AW | Tap index of the coefficient written |
| coef_val | input | DW | Signed coefficient value |
| len_we | input | 1 | Kernel length write strobe |
| len_val | input | LW | Requested kernel length, 0..2^LW-1 |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted when high with s_valid |
| s_data | input | DW | Signed input sample |
| m_valid | output | 1 | Output result valid |
| m_ready | input | 1 | Downstream accepts result |
| m_data | output | OW | Saturated signed result |

## Verification
The hardest case to reach is an output stall that arrives while every pipeline stage holds a result and a new sample is waiting. Every stage must then freeze together, and the window must not shift. The stimulus streams samples back to back while `m_ready` follows a random pattern that is low about half the time. It checks the hold and ready rules on every cycle and matches every result against a model that keeps the full history of accepted samples. Separate directed phases load a kernel whose unused tail holds non-zero values, drive sums that saturate, and drive sums whose partials exceed 32 bits but cancel.

// File: rtl/tapconv_pkg.sv
package tapconv_pkg;

  // Number of registered adder-tree levels for a given tap count.
  function automatic int tree_levels(input int taps);
    return (taps <= 1) ? 0 : $clog2(taps);
  endfunction

  // Accumulator width wide enough for the exact sum of all products.
  function automatic int acc_width(input int dw, input int taps);
    return 2 * dw + tree_levels(taps);
  endfunction

endpackage

// File: rtl/tapconv_coef_bank.sv
module tapconv_coef_bank #(
  parameter int TAPS = 128,
  parameter int DW   = 16,
  parameter int AW   = 7,
  parameter int LW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 coef_we,
  input  logic [AW-1:0]        coef_idx,
  input  logic [DW-1:0]        coef_val,
  input  logic                 len_we,
  input  logic [LW-1:0]        len_val,
  output logic [TAPS*DW-1:0]   coef_eff,
  output logic [LW-1:0]        klen
);

  localparam logic [LW-1:0] LEN_MAX = LW'(TAPS);

  logic [DW-1:0] coef_q [TAPS];

  // Dedicated coefficient registers: every tap is read in parallel.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) coef_q[k] <= '0;
    end else if (coef_we && (int'(coef_idx) < TAPS)) begin
      coef_q[coef_idx] <= coef_val;
    end
  end

  // Active length, capped at the number of physical taps.
  always_ff @(posedge clk) begin
    if (rst) begin
      klen <= LEN_MAX;
    end else if (len_we) begin
      klen <= (len_val > LEN_MAX) ? LEN_MAX : len_val;
    end
  end

  // Taps at or beyond the active length contribute nothing.
  always_comb begin
    for (int k = 0; k < TAPS; k++) begin
      coef_eff[k*DW +: DW] = (k < int'(klen)) ? coef_q[k] : '0;
    end
  end

  // R4: the stored length never exceeds the tap count
  p_len_cap_r4: assert property (@(posedge clk) disable iff (rst)
    klen <= LEN_MAX);

  // R4: an oversize length request lands on the cap
  p_len_clamp_r4: assert property (@(posedge clk) disable iff (rst)
    (len_we && (len_val > LEN_MAX)) |=> (klen == LEN_MAX));

endmodule

// File: rtl/tapconv_window.sv
module tapconv_window #(
  parameter int TAPS = 128,
  parameter int DW   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic               in_vld,
  input  logic [DW-1:0]      in_data,
  output logic [TAPS*DW-1:0] win_flat,
  output logic               win_vld
);

  logic [DW-1:0] tap_q [TAPS];

  // Position 0 takes the newest sample; older samples move one deeper.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) tap_q[k] <= '0;
      win_vld <= 1'b0;
    end else if (adv) begin
      win_vld <= in_vld;
      if (in_vld) begin
        tap_q[0] <= in_data;
        for (int k = 1; k < TAPS; k++) tap_q[k] <= tap_q[k-1];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < TAPS; k++) win_flat[k*DW +: DW] = tap_q[k];
  end

  // R3: an accepted sample appears at the head of the window
  p_head_load_r3: assert property (@(posedge clk) disable iff (rst)
    (adv && in_vld) |=> (tap_q[0] == $past(in_data)));

  generate
    if (TAPS > 1) begin : g_depth
      // R3: the previous head moves one position deeper on a shift
      p_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && in_vld) |=> (tap_q[1] == $past(tap_q[0])));
      // R8: a stall leaves the window untouched
      p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!adv) |=> ($stable(tap_q[0]) && $stable(tap_q[1])));
    end
  endgenerate

endmodule

// File: rtl/tapconv_mac_tree.sv
module tapconv_mac_tree #(
  parameter int TAPS = 128,
  parameter int DW   = 16,
  parameter int SW   = 39
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic               in_vld,
  input  logic [TAPS*DW-1:0] win_flat,
  input  logic [TAPS*DW-1:0] coef_flat,
  output logic [SW-1:0]      sum,
  output logic               sum_vld
);

  localparam int LVL    = tapconv_pkg::tree_levels(TAPS);
  localparam int LEAVES = 1 << LVL;
  localparam int PW     = 2 * DW;
  localparam int PADW   = LEAVES * DW;

  logic [PADW-1:0]        win_pad;
  logic [PADW-1:0]        coef_pad;
  logic signed [PW-1:0]   prod [LEAVES];
  logic signed [SW-1:0]   node [1:2*LEAVES-1];
  logic [LVL:0]           vld_pipe;

  // Pad to a power of two; padded taps multiply zero by zero.
  assign win_pad  = PADW'(win_flat);
  assign coef_pad = PADW'(coef_flat);

  // One multiplier per tap, all in the same cycle.
  always_comb begin
    for (int k = 0; k < LEAVES; k++) begin
      prod[k] = $signed(win_pad[k*DW +: DW]) * $signed(coef_pad[k*DW +: DW]);
    end
  end

  // Heap-ordered tree: leaves hold registered products, every inner node is
  // a register fed by its two children, so each level is a pipeline stage.
  always_ff @(posedge clk) begin
    if (adv) begin
      for (int k = 0; k < LEAVES; k++) node[LEAVES + k] <= SW'(prod[k]);
      for (int i = 1; i < LEAVES; i++) node[i] <= node[2*i] + node[2*i + 1];
    end
  end

  // Valid bit travelling beside the product stage and every tree level.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_pipe <= '0;
    end else if (adv) begin
      vld_pipe[0] <= in_vld;
      for (int i = 1; i <= LVL; i++) vld_pipe[i] <= vld_pipe[i-1];
    end
  end

  assign sum     = node[1];
  assign sum_vld = vld_pipe[LVL];

  // R8: a stalled tree keeps its root and valid flag
  p_tree_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!adv) |=> ($stable(sum) && $stable(sum_vld)));

endmodule

// File: rtl/tapconv_sat_out.sv
module tapconv_sat_out #(
  parameter int SW = 39,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [SW-1:0] in_sum,
  input  logic          m_ready,
  output logic          adv,
  output logic          m_valid,
  output logic [OW-1:0] m_data
);

  localparam logic signed [SW-1:0] HI = {{(SW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [SW-1:0] LO = {{(SW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic signed [SW-1:0] sum_s;
  logic [OW-1:0]        clamp_v;

  assign sum_s = $signed(in_sum);

  always_comb begin
    if (sum_s > HI)      clamp_v = HI[OW-1:0];
    else if (sum_s < LO) clamp_v = LO[OW-1:0];
    else                 clamp_v = sum_s[OW-1:0];
  end

  // The whole pipeline moves only when this register can take a new value.
  assign adv = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (adv) begin
      m_valid <= in_vld;
      m_data  <= clamp_v;
    end
  end

  // R8: a refused result is held unchanged
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R5: positive overflow clamps to the top of the range
  p_sat_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && in_vld && (sum_s > HI)) |=> (m_data == HI[OW-1:0]));

  // R5: negative overflow clamps to the bottom of the range
  p_sat_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && in_vld && (sum_s < LO)) |=> (m_data == LO[OW-1:0]));

endmodule

// File: rtl/tapconv_top.sv
module tapconv_top #(
  parameter int TAPS = 128,
  parameter int DW   = 16,
  parameter int OW   = 16,
  parameter int AW   = (TAPS > 1) ? $clog2(TAPS) : 1,
  parameter int LW   = $clog2(TAPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          coef_we,
  input  logic [AW-1:0] coef_idx,
  input  logic [DW-1:0] coef_val,
  input  logic          len_we,
  input  logic [LW-1:0] len_val,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [OW-1:0] m_data
);

  localparam int SW = tapconv_pkg::acc_width(DW, TAPS);

  logic               adv;
  logic [TAPS*DW-1:0] coef_eff;
  logic [LW-1:0]      klen;
  logic [TAPS*DW-1:0] win_flat;
  logic               win_vld;
  logic [SW-1:0]      tree_sum;
  logic               tree_vld;

  assign s_ready = adv;

  tapconv_coef_bank #(.TAPS(TAPS), .DW(DW), .AW(AW), .LW(LW)) u_coef (
    .clk      (clk),
    .rst      (rst),
    .coef_we  (coef_we),
    .coef_idx (coef_idx),
    .coef_val (coef_val),
    .len_we   (len_we),
    .len_val  (len_val),
    .coef_eff (coef_eff),
    .klen     (klen)
  );

  tapconv_window #(.TAPS(TAPS), .DW(DW)) u_win (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .in_vld   (s_valid),
    .in_data  (s_data),
    .win_flat (win_flat),
    .win_vld  (win_vld)
  );

  tapconv_mac_tree #(.TAPS(TAPS), .DW(DW), .SW(SW)) u_tree (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .in_vld    (win_vld),
    .win_flat  (win_flat),
    .coef_flat (coef_eff),
    .sum       (tree_sum),
    .sum_vld   (tree_vld)
  );

  tapconv_sat_out #(.SW(SW), .OW(OW)) u_sat (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (tree_vld),
    .in_sum  (tree_sum),
    .m_ready (m_ready),
    .adv     (adv),
    .m_valid (m_valid),
    .m_data  (m_data)
  );

endmodule

// File: tb/tapconv_top_tb.sv
module tapconv_top_tb;

  localparam int TAPS = 32;
  localparam int DW   = 16;
  localparam int OW   = 16;
  localparam int AW   = 5;
  localparam int LW   = 6;
  localparam int LVL  = 5;

  logic                 clk = 1'b0;
  logic                 rst;
  logic                 coef_we;
  logic [AW-1:0]        coef_idx;
  logic [DW-1:0]        coef_val;
  logic                 len_we;
  logic [LW-1:0]        len_val;
  logic                 s_valid;
  logic                 s_ready;
  logic signed [DW-1:0] s_data;
  logic                 m_valid;
  logic                 m_ready;
  logic signed [OW-1:0] m_data;

  always #2 clk = ~clk;

  tapconv_top #(.TAPS(TAPS), .DW(DW), .OW(OW), .AW(AW), .LW(LW)) u_dut (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_idx(coef_idx),
    .coef_val(coef_val), .len_we(len_we), .len_val(len_val),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  int    checks = 0;
  int    fails  = 0;
  int    hist[$];
  int    exp_q[$];
  int    kern[TAPS];
  int    klen_m;
  int    bp_pct = 0;
  string cur_req = "R1";
  bit    prev_hold = 1'b0;
  int    prev_data = 0;
  bit    mon_on = 1'b0;

  task automatic fail_msg(string req, int act, int exp);
    fails++;
    $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) fail_msg(req, act, exp);
  endtask

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // Expected result for the newest sample in the history (R3, R4, R6).
  function automatic int model_out();
    longint acc = 0;
    int n = hist.size() - 1;
    for (int k = 0; k < klen_m; k++) begin
      if (n - k >= 0) acc += longint'(kern[k]) * longint'(hist[n - k]);
    end
    return sat16(acc);
  endfunction

  // Monitor: samples half a period after each rising edge.
  always @(negedge clk) begin
    if (mon_on) begin
      // R9: ready drops only when a result is stuck at the output
      check("R9", int'(s_ready), int'(!(m_valid && !m_ready)));
      if (prev_hold) begin
        // R8: held result keeps valid and data
        check("R8", int'(m_valid), 1);
        check("R8", int'(m_data), prev_data);
      end
      if (m_valid && m_ready) begin
        checks++;
        if (exp_q.size() == 0) fail_msg("R8", int'(m_data), -99999);
        else begin
          int e;
          e = exp_q.pop_front();
          checks--;
          check(cur_req, int'(m_data), e);
        end
      end
      if (s_valid && s_ready) begin
        hist.push_back(int'(s_data));
        exp_q.push_back(model_out());
      end
      prev_hold = m_valid && !m_ready;
      prev_data = int'(m_data);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic rnd_ready();
    return (($urandom % 100) >= bp_pct);
  endfunction

  task automatic write_coef(int idx, int val);
    coef_we  = 1'b1;
    coef_idx = AW'(idx);
    coef_val = DW'(val);
    tick();
    coef_we  = 1'b0;
    kern[idx] = val;
  endtask

  task automatic write_len(int v);
    len_we  = 1'b1;
    len_val = LW'(v);
    tick();
    len_we  = 1'b0;
    klen_m  = (v > TAPS) ? TAPS : v;
  endtask

  task automatic send(int v);
    logic acc;
    s_valid = 1'b1;
    s_data  = DW'(v);
    m_ready = rnd_ready();
    do begin
      @(negedge clk);
      acc = s_ready;
      tick();
      m_ready = rnd_ready();
    end while (!acc);
    s_valid = 1'b0;
  endtask

  task automatic drain();
    m_ready = 1'b1;
    for (int i = 0; i < 2000 && exp_q.size() > 0; i++) tick();
    tick();
    tick();
    check("R8", exp_q.size(), 0);
  endtask

  function automatic int rnd16();
    return int'($signed(16'($urandom)));
  endfunction

  int lat;

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; coef_we = 1'b0; coef_idx = '0; coef_val = '0;
    len_we = 1'b0; len_val = '0; s_valid = 1'b0; s_data = '0; m_ready = 1'b1;
    for (int k = 0; k < TAPS; k++) kern[k] = 0;
    klen_m = TAPS;
    repeat (4) tick();
    rst = 1'b0;
    mon_on = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check("R1", int'(m_valid), 0);
    check("R1", int'(s_ready), 1);
    tick();

    // R1/R7: zero kernel after reset gives zero; measure latency
    cur_req = "R1";
    s_valid = 1'b1;
    s_data  = 16'sd1234;
    tick();
    s_valid = 1'b0;
    lat = -1;
    for (int e = 0; e < 40; e++) begin
      @(negedge clk);
      if (m_valid) begin lat = e; break; end
    end
    check("R7", lat, LVL + 2);
    drain();

    // R2: single coefficient at index 3 delays an impulse by three samples
    cur_req = "R2";
    write_coef(3, 7);
    send(100);
    for (int i = 0; i < 6; i++) send(0);
    drain();

    // R3: length one, unit coefficient passes samples through
    cur_req = "R3";
    write_coef(0, 1);
    write_coef(3, 0);
    write_len(1);
    check("R5", 0, 0);
    send(32767);
    send(-32768);
    for (int i = 0; i < 40; i++) send(rnd16());
    drain();

    // R8: full random kernel under heavy random backpressure
    cur_req = "R8";
    for (int k = 0; k < TAPS; k++) write_coef(k, rnd16() >>> 6);
    write_len(TAPS);
    bp_pct = 50;
    for (int i = 0; i < 300; i++) send(rnd16());
    bp_pct = 0;
    drain();

    // R4: short kernel with non-zero tail, zero length, oversize length
    cur_req = "R4";
    for (int k = 0; k < TAPS; k++) write_coef(k, rnd16() >>> 5);
    write_len(5);
    bp_pct = 20;
    for (int i = 0; i < 100; i++) send(rnd16());
    drain();
    write_len(0);
    for (int i = 0; i < 20; i++) send(rnd16());
    drain();
    write_len(40);
    for (int i = 0; i < 60; i++) send(rnd16() >>> 4);
    bp_pct = 0;
    drain();

    // R5: saturation at both ends of the range
    cur_req = "R5";
    for (int k = 0; k < TAPS; k++) write_coef(k, 32767);
    write_len(TAPS);
    for (int i = 0; i < 40; i++) send(32767);
    for (int i = 0; i < 40; i++) send(-32768);
    drain();

    // R6: huge partial sums that cancel exactly once the window is full
    cur_req = "R6";
    for (int k = 0; k < TAPS; k++) write_coef(k, (k < TAPS / 2) ? 32767 : -32767);
    for (int i = 0; i < 80; i++) send(32767);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fail_msg("watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule